// File: doc/BRIEF.md
# Write-Through Invalidate Snooping Cache Controller

This block sits between one processor and a single shared atomic bus in a small shared-memory system. It keeps a direct-mapped cache of one-word lines coherent with the other caches on the bus using a two-state protocol. A line is either present and usable (valid) or unusable (invalid). A load that finds a valid matching line is answered from the cache without touching the bus. A load that misses fetches the word over the bus, fills the line and marks it valid.

Every store goes to the bus as a write. A valid matching line takes the new data. An absent line is not allocated. Whenever another master's bus write names an address this cache holds, the line is dropped during that transaction. Later loads of that address then miss and fetch the value that was just written.

The processor side uses a hold-until-done handshake. The processor keeps its request, address and data steady until a one-cycle ready pulse, and drops the request in the cycle after the pulse. On the bus side the controller raises a request, waits for a grant, then drives the command until the memory signals done. The shared bus lines are also fed back to the snoop inputs. The controller ignores them while it holds the grant itself.

Top module: `wt_snoop_cache`

## Requirements
- R1: Synchronous active-high reset clears every line's valid bit and leaves `cpu_ready` and `bus_req` low; the first load to any address after reset goes to the bus.
- R2: A load that matches a valid line (index = low `log2(LINES)` address bits, tag = the remaining bits) returns the cached word with `cpu_ready` one cycle after the request is taken, and raises no bus request.
- R3: A load that misses performs one bus read (`bus_cmd_we`=0), returns the word supplied on `bus_rdata`, and makes the line valid so that a repeat load hits.
- R4: Every store performs exactly one bus write (`bus_cmd_we`=1) with its address and data; if the line is valid and matching, its data becomes the stored word and it stays valid.
- R5: A store to an address not held leaves the cache unchanged (no allocation); a following load of that address misses.
- R6: A bus write by another master to an address held valid invalidates that line; the next local load misses and returns the newly written value.
- R7: Only writes by other masters to a matching tag invalidate: the controller's own transactions, other masters' reads, and other masters' writes to a different tag at the same index leave the line valid.
- R8: `bus_cmd_valid` is asserted only while `bus_gnt` is high; `bus_req` stays high from the request until `bus_done` and is low in the cycle after `bus_done`.
- R9: `cpu_ready` is a single-cycle pulse per operation; for bus operations it is high in the cycle right after `bus_done`.
- R10: A load whose index matches a valid line with a different tag misses and replaces that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor operation request, held until ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | AW | Word address of the operation |
| cpu_wdata | input | DW | Store data |
| cpu_rdata | output | DW | Load result, valid with cpu_ready |
| cpu_ready | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus ownership grant |
| bus_cmd_valid | output | 1 | Command driven on the bus |
| bus_cmd_we | output | 1 | Bus command type, 1 = write |
| bus_cmd_addr | output | AW | Bus command address |
| bus_cmd_wdata | output | DW | Bus write data |
| bus_done | input | 1 | Memory completion of the current transaction |
| bus_rdata | input | DW | Memory read data, valid with bus_done |
| snp_valid | input | 1 | Shared bus command valid, as seen by all caches |
| snp_we | input | 1 | Shared bus command type |
| snp_addr | input | AW | Shared bus address |

## Verification
A load hit must show `cpu_ready` exactly one cycle after the request is taken. The bench counts the cycles from driving the request to seeing ready and compares the count with one. For bus operations the due cycle is the one after `bus_done`. In that cycle a falling-edge monitor expects `cpu_ready` high and `bus_req` low. It also checks that every cycle with a driven command has the grant. Hit or miss is judged at the ports by counting the completed bus transactions of each master across an operation. All inputs are driven and all outputs sampled on the falling clock edge, so each result is read half a cycle after the edge that produces it.

// File: rtl/wtc_pkg.sv
`timescale 1ns/1ps
package wtc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARB  = 2'd1,
        ST_XFER = 2'd2,
        ST_RESP = 2'd3
    } wtc_state_e;

    typedef struct packed {
        logic fill;
        logic update;
    } wtc_wr_ctl_t;

    function automatic logic wtc_on_bus(input wtc_state_e s);
        return (s == ST_ARB) || (s == ST_XFER);
    endfunction

endpackage

// File: rtl/wtc_line_store.sv
`timescale 1ns/1ps
module wtc_line_store
    import wtc_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int LINES = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] lk_addr,
    output logic          lk_hit,
    output logic [DW-1:0] lk_data,
    input  logic [AW-1:0] sn_addr,
    output logic          sn_hit,
    input  wtc_wr_ctl_t   wr_ctl,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          inval_en
);
    localparam int IW = $clog2(LINES);
    localparam int TW = AW - IW;

    logic [LINES-1:0] vld_q;
    logic [LINES-1:0] vld_d;
    logic [TW-1:0]    tag_q [LINES];
    logic [DW-1:0]    dat_q [LINES];

    logic [IW-1:0] lk_idx, sn_idx, wr_idx;
    assign lk_idx = lk_addr[IW-1:0];
    assign sn_idx = sn_addr[IW-1:0];
    assign wr_idx = wr_addr[IW-1:0];

    assign lk_hit  = vld_q[lk_idx] && (tag_q[lk_idx] == lk_addr[AW-1:IW]);
    assign lk_data = dat_q[lk_idx];
    assign sn_hit  = vld_q[sn_idx] && (tag_q[sn_idx] == sn_addr[AW-1:IW]);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic set_g, clr_g;
        assign set_g    = wr_ctl.fill && (wr_idx == IW'(g));
        assign clr_g    = inval_en && (sn_idx == IW'(g));
        assign vld_d[g] = set_g ? 1'b1 : (clr_g ? 1'b0 : vld_q[g]);
    end

    always_ff @(posedge clk) begin
        if (rst) vld_q <= '0;
        else     vld_q <= vld_d;
    end

    always_ff @(posedge clk) begin
        if (wr_ctl.fill) begin
            tag_q[wr_idx] <= wr_addr[AW-1:IW];
            dat_q[wr_idx] <= wr_data;
        end else if (wr_ctl.update) begin
            dat_q[wr_idx] <= wr_data;
        end
    end

    p_inval_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (inval_en && !wr_ctl.fill) |=> !vld_q[$past(sn_idx)]);

    p_fill_sets_r3: assert property (@(posedge clk) disable iff (rst)
        wr_ctl.fill |=> vld_q[$past(wr_idx)]);

endmodule

// File: rtl/wtc_snoop_filter.sv
`timescale 1ns/1ps
module wtc_snoop_filter (
    input  logic clk,
    input  logic rst,
    input  logic snp_valid,
    input  logic snp_we,
    input  logic own_gnt,
    input  logic sn_hit,
    output logic inval_en
);
    assign inval_en = snp_valid && snp_we && !own_gnt && sn_hit;

    p_foreign_read_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && !snp_we) |-> !inval_en);

endmodule

// File: rtl/wtc_ctrl_fsm.sv
`timescale 1ns/1ps
module wtc_ctrl_fsm
    import wtc_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic          cpu_ready,
    output logic [DW-1:0] cpu_rdata,
    input  logic          lk_hit,
    input  logic [DW-1:0] lk_data,
    output logic [AW-1:0] lk_addr,
    output logic          bus_req,
    output logic          bus_cmd_valid,
    output logic          bus_cmd_we,
    output logic [AW-1:0] bus_cmd_addr,
    output logic [DW-1:0] bus_cmd_wdata,
    input  logic          bus_gnt,
    input  logic          bus_done,
    input  logic [DW-1:0] bus_rdata,
    output wtc_wr_ctl_t   wr_ctl,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);
    wtc_state_e    state_q, state_d;
    logic          op_we_q;
    logic [AW-1:0] op_addr_q;
    logic [DW-1:0] op_wdata_q;
    logic [DW-1:0] rdata_q;
    logic          xfer_end;

    assign xfer_end = (state_q == ST_XFER) && bus_done;
    assign lk_addr  = (state_q == ST_IDLE) ? cpu_addr : op_addr_q;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (cpu_req) state_d = (!cpu_we && lk_hit) ? ST_RESP : ST_ARB;
            ST_ARB:  if (bus_gnt) state_d = ST_XFER;
            ST_XFER: if (bus_done) state_d = ST_RESP;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            op_we_q    <= 1'b0;
            op_addr_q  <= '0;
            op_wdata_q <= '0;
            rdata_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && cpu_req) begin
                op_we_q    <= cpu_we;
                op_addr_q  <= cpu_addr;
                op_wdata_q <= cpu_wdata;
                if (!cpu_we && lk_hit) rdata_q <= lk_data;
            end
            if (xfer_end && !op_we_q) rdata_q <= bus_rdata;
        end
    end

    assign bus_req       = wtc_on_bus(state_q);
    assign bus_cmd_valid = (state_q == ST_XFER);
    assign bus_cmd_we    = op_we_q;
    assign bus_cmd_addr  = op_addr_q;
    assign bus_cmd_wdata = op_wdata_q;
    assign cpu_ready     = (state_q == ST_RESP);
    assign cpu_rdata     = rdata_q;

    assign wr_ctl.fill   = xfer_end && !op_we_q;
    assign wr_ctl.update = xfer_end && op_we_q && lk_hit;
    assign wr_addr       = op_addr_q;
    assign wr_data       = op_we_q ? op_wdata_q : bus_rdata;

    p_cmd_needs_gnt_r8: assert property (@(posedge clk) disable iff (rst)
        bus_cmd_valid |-> bus_gnt);

    p_req_release_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_cmd_valid && bus_done) |=> !bus_req);

    p_ready_after_done_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_cmd_valid && bus_done) |=> cpu_ready);

    p_ready_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |=> !cpu_ready);

    p_hit_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && cpu_req && !cpu_we && lk_hit) |=> (cpu_ready && !bus_req));

endmodule

// File: rtl/wt_snoop_cache.sv
`timescale 1ns/1ps
module wt_snoop_cache
    import wtc_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int LINES = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    output logic          cpu_ready,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic          bus_cmd_valid,
    output logic          bus_cmd_we,
    output logic [AW-1:0] bus_cmd_addr,
    output logic [DW-1:0] bus_cmd_wdata,
    input  logic          bus_done,
    input  logic [DW-1:0] bus_rdata,
    input  logic          snp_valid,
    input  logic          snp_we,
    input  logic [AW-1:0] snp_addr
);
    logic          lk_hit, sn_hit, inval_en;
    logic [DW-1:0] lk_data;
    logic [AW-1:0] lk_addr, wr_addr;
    logic [DW-1:0] wr_data;
    wtc_wr_ctl_t   wr_ctl;

    wtc_ctrl_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .lk_hit(lk_hit), .lk_data(lk_data), .lk_addr(lk_addr),
        .bus_req(bus_req), .bus_cmd_valid(bus_cmd_valid), .bus_cmd_we(bus_cmd_we),
        .bus_cmd_addr(bus_cmd_addr), .bus_cmd_wdata(bus_cmd_wdata),
        .bus_gnt(bus_gnt), .bus_done(bus_done), .bus_rdata(bus_rdata),
        .wr_ctl(wr_ctl), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    wtc_line_store #(.AW(AW), .DW(DW), .LINES(LINES)) u_store (
        .clk(clk), .rst(rst),
        .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_data(lk_data),
        .sn_addr(snp_addr), .sn_hit(sn_hit),
        .wr_ctl(wr_ctl), .wr_addr(wr_addr), .wr_data(wr_data),
        .inval_en(inval_en)
    );

    wtc_snoop_filter u_snoop (
        .clk(clk), .rst(rst),
        .snp_valid(snp_valid), .snp_we(snp_we), .own_gnt(bus_gnt),
        .sn_hit(sn_hit), .inval_en(inval_en)
    );

    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (!cpu_ready && !bus_req));

endmodule

// File: tb/test_wt_snoop_cache.sv
`timescale 1ns/1ps
module test_wt_snoop_cache;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int LAT = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [1:0]    cpu_req = '0;
    logic [1:0]    cpu_we  = '0;
    logic [AW-1:0] cpu_addr  [2];
    logic [DW-1:0] cpu_wdata [2];
    logic [DW-1:0] cpu_rdata [2];
    logic [1:0]    cpu_ready;
    logic [1:0]    bus_req, cmd_valid, cmd_we;
    logic [AW-1:0] cmd_addr  [2];
    logic [DW-1:0] cmd_wdata [2];
    logic [1:0]    gnt_q;

    logic          sh_valid, sh_we, done;
    logic [AW-1:0] sh_addr;
    logic [DW-1:0] sh_wdata, sh_rdata;
    logic [3:0]    lat_cnt;
    logic [DW-1:0] mem    [256];
    logic [DW-1:0] golden [256];

    int n_chk = 0, n_fail = 0;
    int txn_cnt [2];
    bit pend [2];
    bit prev_rdy [2];

    function automatic logic [DW-1:0] init_word(input int a);
        return 32'hC0DE_0000 ^ (a * 32'h0001_0203);
    endfunction

    initial begin
        for (int i = 0; i < 2; i++) begin
            cpu_addr[i] = '0; cpu_wdata[i] = '0;
            txn_cnt[i] = 0; pend[i] = 0; prev_rdy[i] = 0;
        end
        for (int i = 0; i < 256; i++) golden[i] = init_word(i);
    end

    wt_snoop_cache #(.AW(AW), .DW(DW)) i_wt_snoop_cache (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req[0]), .cpu_we(cpu_we[0]), .cpu_addr(cpu_addr[0]), .cpu_wdata(cpu_wdata[0]),
        .cpu_rdata(cpu_rdata[0]), .cpu_ready(cpu_ready[0]),
        .bus_req(bus_req[0]), .bus_gnt(gnt_q[0]), .bus_cmd_valid(cmd_valid[0]),
        .bus_cmd_we(cmd_we[0]), .bus_cmd_addr(cmd_addr[0]), .bus_cmd_wdata(cmd_wdata[0]),
        .bus_done(done), .bus_rdata(sh_rdata),
        .snp_valid(sh_valid), .snp_we(sh_we), .snp_addr(sh_addr)
    );

    wt_snoop_cache #(.AW(AW), .DW(DW)) i_wt_snoop_cache_peer (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req[1]), .cpu_we(cpu_we[1]), .cpu_addr(cpu_addr[1]), .cpu_wdata(cpu_wdata[1]),
        .cpu_rdata(cpu_rdata[1]), .cpu_ready(cpu_ready[1]),
        .bus_req(bus_req[1]), .bus_gnt(gnt_q[1]), .bus_cmd_valid(cmd_valid[1]),
        .bus_cmd_we(cmd_we[1]), .bus_cmd_addr(cmd_addr[1]), .bus_cmd_wdata(cmd_wdata[1]),
        .bus_done(done), .bus_rdata(sh_rdata),
        .snp_valid(sh_valid), .snp_we(sh_we), .snp_addr(sh_addr)
    );

    // Shared bus: registered arbiter, mux, memory responder
    always_ff @(posedge clk) begin
        if (rst) gnt_q <= '0;
        else if (gnt_q == 2'b00) begin
            if (bus_req[0])      gnt_q <= 2'b01;
            else if (bus_req[1]) gnt_q <= 2'b10;
        end else if ((gnt_q[0] && !bus_req[0]) || (gnt_q[1] && !bus_req[1])) gnt_q <= '0;
    end

    assign sh_valid = (gnt_q[0] && cmd_valid[0]) || (gnt_q[1] && cmd_valid[1]);
    assign sh_we    = gnt_q[1] ? cmd_we[1]    : cmd_we[0];
    assign sh_addr  = gnt_q[1] ? cmd_addr[1]  : cmd_addr[0];
    assign sh_wdata = gnt_q[1] ? cmd_wdata[1] : cmd_wdata[0];
    assign done     = sh_valid && (lat_cnt == 4'(LAT));
    assign sh_rdata = mem[sh_addr[7:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_cnt <= '0;
            for (int i = 0; i < 256; i++) mem[i] <= init_word(i);
        end else begin
            if (done) lat_cnt <= '0;
            else if (sh_valid) lat_cnt <= lat_cnt + 4'd1;
            if (done && sh_we) mem[sh_addr[7:0]] <= sh_wdata;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Handshake monitor (R8, R9), sampled on the falling edge
    always @(negedge clk) begin
        if (!rst) begin
            for (int m = 0; m < 2; m++) begin
                if (cmd_valid[m] && !gnt_q[m]) chk(0, "R8 command without grant", 0, 1);
                if (pend[m]) begin
                    chk(cpu_ready[m] == 1'b1, "R9 ready after done", DW'(cpu_ready[m]), 1);
                    chk(bus_req[m] == 1'b0, "R8 request released", DW'(bus_req[m]), 0);
                    pend[m] = 0;
                end
                if (cmd_valid[m] && done && gnt_q[m]) begin
                    txn_cnt[m]++;
                    pend[m] = 1;
                end
                if (cpu_ready[m] && prev_rdy[m]) chk(0, "R9 ready longer than one cycle", 2, 1);
                prev_rdy[m] = cpu_ready[m];
            end
        end
    end

    task automatic cpu_op(input int m, input bit we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                          output logic [DW-1:0] rd, output int lat, output int ntx);
        int t0;
        int n = 0;
        @(negedge clk);
        t0 = txn_cnt[m];
        cpu_req[m] = 1'b1; cpu_we[m] = we; cpu_addr[m] = a; cpu_wdata[m] = wd;
        do begin @(negedge clk); n++; end while (!cpu_ready[m] && n < 500);
        if (!cpu_ready[m]) chk(0, "R9 operation timeout", 0, 1);
        rd = cpu_rdata[m];
        lat = n;
        cpu_req[m] = 1'b0;
        ntx = txn_cnt[m] - t0;
        if (we) golden[a[7:0]] = wd;
    endtask

    task automatic rd_expect(input int m, input logic [AW-1:0] a, input int exp_tx, input string req);
        logic [DW-1:0] d; int lat, ntx;
        cpu_op(m, 1'b0, a, '0, d, lat, ntx);
        chk(d == golden[a[7:0]], {req, " load data"}, d, golden[a[7:0]]);
        chk(ntx == exp_tx, {req, " bus transactions on load"}, DW'(ntx), DW'(exp_tx));
        if (exp_tx == 0) chk(lat == 1, {req, " hit latency"}, DW'(lat), 1);
    endtask

    task automatic wr_expect(input int m, input logic [AW-1:0] a, input logic [DW-1:0] v, input string req);
        logic [DW-1:0] d; int lat, ntx;
        cpu_op(m, 1'b1, a, v, d, lat, ntx);
        chk(ntx == 1, {req, " one bus write per store"}, DW'(ntx), 1);
    endtask

    task automatic t_reset();
        chk(cpu_ready == 2'b00, "R1 ready low after reset", DW'(cpu_ready), 0);
        chk(bus_req == 2'b00, "R1 bus request low after reset", DW'(bus_req), 0);
        rd_expect(0, 16'h0010, 1, "R1 R3 first load misses");
    endtask

    task automatic t_read_hit();
        rd_expect(0, 16'h0010, 0, "R2 repeat load hits");
        rd_expect(0, 16'h0010, 0, "R2 second hit");
    endtask

    task automatic t_write_hit();
        wr_expect(0, 16'h0010, 32'hAAAA_0010, "R4 store to held line");
        chk(mem[8'h10] == 32'hAAAA_0010, "R4 memory written", mem[8'h10], 32'hAAAA_0010);
        rd_expect(0, 16'h0010, 0, "R4 line updated and still valid");
    endtask

    task automatic t_write_miss();
        wr_expect(0, 16'h0023, 32'h5555_0023, "R5 store to absent line");
        rd_expect(0, 16'h0023, 1, "R5 no allocation on store");
        rd_expect(0, 16'h0023, 0, "R3 fill after miss");
    endtask

    task automatic t_snoop_inval();
        rd_expect(1, 16'h0010, 1, "R6 peer fills");
        rd_expect(0, 16'h0010, 0, "R6 local copy held");
        wr_expect(1, 16'h0010, 32'hBEEF_0010, "R6 peer store");
        rd_expect(0, 16'h0010, 1, "R6 invalidated copy misses with new value");
        rd_expect(1, 16'h0010, 0, "R7 own store does not invalidate own line");
    endtask

    task automatic t_snoop_keep();
        rd_expect(0, 16'h0030, 1, "R7 local fill");
        rd_expect(1, 16'h0030, 1, "R7 peer read");
        rd_expect(0, 16'h0030, 0, "R7 foreign read keeps line");
        wr_expect(1, 16'h0040, 32'h1234_0040, "R7 peer store other tag same index");
        rd_expect(0, 16'h0030, 0, "R7 tag mismatch keeps line");
    endtask

    task automatic t_conflict();
        rd_expect(0, 16'h0050, 1, "R10 same index other tag misses");
        rd_expect(0, 16'h0050, 0, "R10 new tag now held");
        rd_expect(0, 16'h0030, 1, "R10 old tag replaced");
    endtask

    task automatic t_concurrent();
        logic [DW-1:0] d0, d1; int l0, l1, n0, n1;
        fork
            cpu_op(0, 1'b1, 16'h0061, 32'h0000_A061, d0, l0, n0);
            cpu_op(1, 1'b1, 16'h0062, 32'h0000_B062, d1, l1, n1);
        join
        chk(n0 == 1, "R8 contended store A completes", DW'(n0), 1);
        chk(n1 == 1, "R8 contended store B completes", DW'(n1), 1);
        rd_expect(1, 16'h0061, 1, "R4 serialized write visible");
        rd_expect(0, 16'h0062, 1, "R4 serialized write visible");
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_read_hit();
        t_write_hit();
        t_write_miss();
        t_snoop_inval();
        t_snoop_keep();
        t_conflict();
        t_concurrent();
        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "R9 watchdog expired", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule